// File: doc/BRIEF.md
# Scrolled Tile Map Address Generator

This block turns a screen pixel position into the video RAM word address of the background map entry that covers it, together with the pixel position inside that 8x8 tile. The horizontal and vertical scroll offsets are added to the screen coordinates first. The scrolled position is then wrapped around a virtual map whose size comes from configuration.

The map height is 32 or 64 tiles. The map width is 64 or 128 tiles, or it follows the visible display width. A 3-bit size code, taken from a field inside an 8-bit configuration byte, selects the dimensions. The visible display width is supplied as a 7-bit field that holds the tile count minus one. A background fetch pipeline uses this block by presenting one position per cycle and reading the entry address and fine offsets one cycle later.

Top module: `tile_map_addr_gen`

## Requirements
- R1: The size code is bits 6:4 of `map_cfg_i`. Bit 7 and bits 3:0 have no effect on any output.
- R2: When size code bits 1:0 are 00, the map width in tiles is `disp_w_i + 1`. For example, 0x1F gives 32 tiles, 0x27 gives 40, 0x00 gives 1 and 0x7F gives 128.
- R3: When size code bits 1:0 are 01, the map width is 64 tiles. When they are 10 or 11, the map width is 128 tiles.
- R4: When size code bit 2 is 0, the map height is 32 tiles. When it is 1, the map height is 64 tiles.
- R5: The map column is ((x + hscroll) >> 3) modulo the map width. The sum x + hscroll is taken at full 11-bit precision, with 10-bit x and 10-bit hscroll.
- R6: The map row is ((y + vscroll) >> 3) modulo the map height. The sum y + vscroll is taken at full 10-bit precision, with 9-bit y and 9-bit vscroll.
- R7: `entry_addr_o` = row * map width + column, counted from word 0 and kept to 15 bits.
- R8: `fine_x_o` is bits 2:0 of x + hscroll, and `fine_y_o` is bits 2:0 of y + vscroll.
- R9: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges. While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_x_i | input | 10 | Screen x position in pixels |
| pix_y_i | input | 9 | Screen y position in pixels |
| hscroll_i | input | 10 | Horizontal scroll offset in pixels |
| vscroll_i | input | 9 | Vertical scroll offset in pixels |
| map_cfg_i | input | 8 | Configuration byte; bits 6:4 hold the map size code |
| disp_w_i | input | 7 | Visible display width in tiles, minus one |
| entry_addr_o | output | 15 | Word address of the map entry |
| fine_x_o | output | 3 | Pixel column inside the tile |
| fine_y_o | output | 3 | Pixel row inside the tile |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The bench changes inputs only on falling edges and reads results one time unit after the next rising edge. The latency scenario also reads the outputs just after new inputs are applied, before that edge, and expects the previous result to still be held there. Expected addresses and offsets come from a plain integer model of the modulo and multiply rules.

// File: rtl/tmap_pkg.sv
package tmap_pkg;
  localparam int unsigned TILE_SHIFT = 3;
  localparam int unsigned CODE_W     = 3;

  typedef enum logic [1:0] {
    WSEL_DISP = 2'b00,
    WSEL_MID  = 2'b01,
    WSEL_WIDE = 2'b10,
    WSEL_WIDX = 2'b11
  } wsel_e;
endpackage

// File: rtl/tmap_size_decode.sv
module tmap_size_decode
  import tmap_pkg::*;
#(
  parameter int unsigned DW_W        = 7,
  parameter int unsigned WT_W        = 8,
  parameter int unsigned HT_W        = 7,
  parameter int unsigned MAP_W_MID   = 64,
  parameter int unsigned MAP_W_WIDE  = 128,
  parameter int unsigned MAP_H_SHORT = 32,
  parameter int unsigned MAP_H_TALL  = 64
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [DW_W-1:0]   disp_w_i,
  output logic [WT_W-1:0]   width_o,
  output logic [HT_W-1:0]   height_o
);
  wsel_e wsel;
  assign wsel = wsel_e'(code_i[1:0]);

  always_comb begin
    unique case (wsel)
      WSEL_DISP: width_o = WT_W'(disp_w_i) + WT_W'(1);
      WSEL_MID:  width_o = WT_W'(MAP_W_MID);
      WSEL_WIDE,
      WSEL_WIDX: width_o = WT_W'(MAP_W_WIDE);
      default:   width_o = WT_W'(MAP_W_WIDE);
    endcase
  end

  assign height_o = code_i[CODE_W-1] ? HT_W'(MAP_H_TALL) : HT_W'(MAP_H_SHORT);
endmodule

// File: rtl/tmap_mod.sv
// Restoring remainder, one conditional subtract per dividend bit.
module tmap_mod #(
  parameter int unsigned N = 8,
  parameter int unsigned D = 8
) (
  input  logic [N-1:0] num_i,
  input  logic [D-1:0] div_i,
  output logic [D-1:0] rem_o
);
  logic [D-1:0] r [0:N];
  assign r[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_stage
    logic [D:0] trial;
    logic [D:0] divx;
    assign divx  = {1'b0, div_i};
    assign trial = {r[g], num_i[N-1-g]};
    assign r[g+1] = (trial >= divx) ? D'(trial - divx) : trial[D-1:0];
  end

  assign rem_o = r[N];
endmodule

// File: rtl/tile_map_addr_gen.sv
module tile_map_addr_gen
  import tmap_pkg::*;
#(
  parameter int unsigned X_W         = 10,
  parameter int unsigned Y_W         = 9,
  parameter int unsigned HS_W        = 10,
  parameter int unsigned VS_W        = 9,
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned CODE_LSB    = 4,
  parameter int unsigned DW_W        = 7,
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned WT_W        = 8,
  parameter int unsigned HT_W        = 7,
  parameter int unsigned MAP_W_MID   = 64,
  parameter int unsigned MAP_W_WIDE  = 128,
  parameter int unsigned MAP_H_SHORT = 32,
  parameter int unsigned MAP_H_TALL  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [X_W-1:0]    pix_x_i,
  input  logic [Y_W-1:0]    pix_y_i,
  input  logic [HS_W-1:0]   hscroll_i,
  input  logic [VS_W-1:0]   vscroll_i,
  input  logic [CFG_W-1:0]  map_cfg_i,
  input  logic [DW_W-1:0]   disp_w_i,
  output logic [ADDR_W-1:0] entry_addr_o,
  output logic [2:0]        fine_x_o,
  output logic [2:0]        fine_y_o
);
  localparam int unsigned SX_W = ((X_W > HS_W) ? X_W : HS_W) + 1;
  localparam int unsigned SY_W = ((Y_W > VS_W) ? Y_W : VS_W) + 1;
  localparam int unsigned CX_W = SX_W - TILE_SHIFT;
  localparam int unsigned CY_W = SY_W - TILE_SHIFT;
  localparam int unsigned PW   = HT_W + WT_W + 1;
  localparam logic [CFG_W-1:0] CODE_MASK = CFG_W'(((1 << CODE_W) - 1) << CODE_LSB);

  logic [CODE_W-1:0] code;
  logic              unused_cfg_bits;
  assign code            = map_cfg_i[CODE_LSB +: CODE_W];
  assign unused_cfg_bits = ^(map_cfg_i & ~CODE_MASK);

  logic [SX_W-1:0] sx;
  logic [SY_W-1:0] sy;
  assign sx = SX_W'(pix_x_i) + SX_W'(hscroll_i);
  assign sy = SY_W'(pix_y_i) + SY_W'(vscroll_i);

  logic [WT_W-1:0] map_w;
  logic [HT_W-1:0] map_h;

  tmap_size_decode #(
    .DW_W(DW_W), .WT_W(WT_W), .HT_W(HT_W),
    .MAP_W_MID(MAP_W_MID), .MAP_W_WIDE(MAP_W_WIDE),
    .MAP_H_SHORT(MAP_H_SHORT), .MAP_H_TALL(MAP_H_TALL)
  ) u_size (
    .code_i   (code),
    .disp_w_i (disp_w_i),
    .width_o  (map_w),
    .height_o (map_h)
  );

  logic [WT_W-1:0] col;
  logic [HT_W-1:0] row;

  tmap_mod #(.N(CX_W), .D(WT_W)) u_col_mod (
    .num_i (sx[SX_W-1:TILE_SHIFT]),
    .div_i (map_w),
    .rem_o (col)
  );

  tmap_mod #(.N(CY_W), .D(HT_W)) u_row_mod (
    .num_i (sy[SY_W-1:TILE_SHIFT]),
    .div_i (map_h),
    .rem_o (row)
  );

  logic [PW-1:0] addr_full;
  assign addr_full = PW'(row) * PW'(map_w) + PW'(col);

  logic [WT_W-1:0] col_q, wid_q;
  logic [HT_W-1:0] row_q, hgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_addr_o <= '0;
      fine_x_o     <= '0;
      fine_y_o     <= '0;
      col_q        <= '0;
      row_q        <= '0;
      wid_q        <= WT_W'(1);
      hgt_q        <= HT_W'(1);
    end else begin
      entry_addr_o <= addr_full[ADDR_W-1:0];
      fine_x_o     <= sx[TILE_SHIFT-1:0];
      fine_y_o     <= sy[TILE_SHIFT-1:0];
      col_q        <= col;
      row_q        <= row;
      wid_q        <= map_w;
      hgt_q        <= map_h;
    end
  end

  // Low-bit sums computed apart from the wide adders.
  logic [2:0] lo_x_chk, lo_y_chk;
  assign lo_x_chk = pix_x_i[2:0] + hscroll_i[2:0];
  assign lo_y_chk = pix_y_i[2:0] + vscroll_i[2:0];

  p_col_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q < wid_q);

  p_row_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    HT_W'(row_q) < hgt_q);

  p_fine_x_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> fine_x_o == $past(lo_x_chk));

  p_fine_y_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> fine_y_o == $past(lo_y_chk));

  p_tall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni && map_cfg_i[CODE_LSB+2] |=> hgt_q == HT_W'(MAP_H_TALL));

  p_wide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni && map_cfg_i[CODE_LSB+1] |=> wid_q == WT_W'(MAP_W_WIDE));
endmodule

// File: tb/tile_map_addr_gen_tb.sv
module tile_map_addr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  pix_x_i = '0;
  logic [8:0]  pix_y_i = '0;
  logic [9:0]  hscroll_i = '0;
  logic [8:0]  vscroll_i = '0;
  logic [7:0]  map_cfg_i = '0;
  logic [6:0]  disp_w_i = '0;
  logic [14:0] entry_addr_o;
  logic [2:0]  fine_x_o, fine_y_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tile_map_addr_gen u_dut (
    .clk_i, .rst_ni, .pix_x_i, .pix_y_i, .hscroll_i, .vscroll_i,
    .map_cfg_i, .disp_w_i, .entry_addr_o, .fine_x_o, .fine_y_o
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_width(int code, int dw);
    case (code & 3)
      0: return dw + 1;
      1: return 64;
      default: return 128;
    endcase
  endfunction

  function automatic int m_addr(int x, int y, int hs, int vs, int code, int dw);
    int w, h;
    w = m_width(code, dw);
    h = (code & 4) ? 64 : 32;
    return ((((y + vs) >> 3) % h) * w + (((x + hs) >> 3) % w)) & 32'h7fff;
  endfunction

  task automatic drive(int x, int y, int hs, int vs, int cfg, int dw);
    @(negedge clk_i);
    pix_x_i = 10'(x); pix_y_i = 9'(y); hscroll_i = 10'(hs);
    vscroll_i = 9'(vs); map_cfg_i = 8'(cfg); disp_w_i = 7'(dw);
  endtask

  task automatic run(string req, int x, int y, int hs, int vs, int cfg, int dw);
    drive(x, y, hs, vs, cfg, dw);
    @(posedge clk_i); #1;
    chk(req, entry_addr_o, m_addr(x, y, hs, vs, (cfg >> 4) & 7, dw));
    chk(req, fine_x_o, (x + hs) & 7);
    chk(req, fine_y_o, (y + vs) & 7);
  endtask

  task automatic t_reset();
    drive(300, 200, 77, 55, 8'h30, 39);
    repeat (2) @(posedge clk_i);
    #1;
    chk("R9 reset addr", entry_addr_o, 0);
    chk("R9 reset fine_x", fine_x_o, 0);
    chk("R9 reset fine_y", fine_y_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_disp_width();
    run("R2 width 32", 100, 40, 13, 6, 8'h00, 8'h1F);
    run("R2 width 40", 319, 239, 90, 20, 8'h00, 8'h27);
    run("R2 width 1", 500, 100, 400, 9, 8'h00, 8'h00);
    run("R2 width 128", 1000, 17, 5, 0, 8'h00, 8'h7F);
  endtask

  task automatic t_fixed_width();
    run("R3 width 64", 600, 33, 300, 3, 8'h10, 8'h1F);
    run("R3 width 128 code10", 900, 70, 500, 11, 8'h20, 8'h1F);
    run("R3 width 128 code11", 900, 70, 500, 11, 8'h30, 8'h1F);
  endtask

  task automatic t_height();
    run("R4 height 32", 8, 300, 0, 250, 8'h00, 8'h1F);
    run("R4 height 64", 8, 300, 0, 250, 8'h40, 8'h1F);
    run("R6 row wrap 64", 0, 511, 0, 511, 8'h50, 8'h1F);
  endtask

  task automatic t_scroll_edges();
    run("R5 col full sum x40", 1023, 0, 1023, 0, 8'h00, 8'h27);
    run("R5 col full sum x64", 1023, 0, 1023, 0, 8'h10, 8'h27);
    run("R7 max addr", 1023, 511, 1023, 511, 8'h60, 8'h00);
    run("R8 fine offsets", 5, 6, 7, 7, 8'h00, 8'h1F);
  endtask

  task automatic t_ignored_bits();
    int a0, fx0, fy0;
    run("R1 base", 345, 123, 222, 99, 8'h10, 8'h27);
    a0 = entry_addr_o; fx0 = fine_x_o; fy0 = fine_y_o;
    drive(345, 123, 222, 99, 8'h9F, 8'h27);
    @(posedge clk_i); #1;
    chk("R1 other bits addr", entry_addr_o, a0);
    chk("R1 other bits fine_x", fine_x_o, fx0);
    chk("R1 other bits fine_y", fine_y_o, fy0);
  endtask

  task automatic t_latency();
    int a_old, a_new;
    run("R9 first", 16, 16, 0, 0, 8'h00, 8'h1F);
    a_old = m_addr(16, 16, 0, 0, 0, 31);
    a_new = m_addr(200, 100, 0, 0, 0, 31);
    drive(200, 100, 0, 0, 8'h00, 8'h1F);
    #2;
    chk("R9 held before edge", entry_addr_o, a_old);
    chk("R9 fine held before edge", fine_x_o, 0);
    @(posedge clk_i); #1;
    chk("R9 updated after edge", entry_addr_o, a_new);
  endtask

  initial begin
    t_reset();
    t_disp_width();
    t_fixed_width();
    t_height();
    t_scroll_edges();
    t_ignored_bits();
    t_latency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule